// File: doc/BRIEF.md
# Chip-Enable Strobed Memory Cycle Sequencer

This block sits on the host side of a one-bit-wide static memory whose address is captured when its active-low chip enable falls. It turns single read and write requests, offered through a valid/ready handshake, into a complete strobe sequence. It drives the address, the active-low enable, the active-low write strobe, a data bit and a driver enable for a shared data line. For a read it returns the data bit with a one-clock valid pulse. Every minimum interval is a parameter counted in clock cycles.

Each memory cycle opens by presenting the address and lowering the enable on the same clock edge. A read keeps the write strobe high and samples the memory output on the edge that raises the enable. A write lowers the write strobe together with the enable. It turns the data driver on only after the memory output has had time to turn off. It keeps the data driven for the setup interval, then raises the write strobe before the enable rises. After each cycle the enable stays high for a recovery interval. That interval is long enough to meet both the minimum high time and the minimum total cycle time. The request port is ready only once the recovery interval has run out.

With the default counts (50 MHz intent), a read holds the enable low for 9 cycles. A write holds the enable low for 11 cycles, with the write strobe low for the first 10. The recovery interval is 5 cycles after either kind of cycle.

Top module: `strobe_mem_seq`

## Requirements
- R1: While reset is asserted, and until the request port becomes ready, mem_e_n and mem_w_n are 1, mem_d_oe is 0 and rsp_valid is 0. req_ready rises no earlier than the third rising clock edge after rst_n is released.
- R2: req_ready is 1 only while no cycle is in progress and recovery has expired. A request is accepted on a rising edge where req_valid and req_ready are both 1. On that edge mem_addr takes req_addr and mem_e_n falls, and mem_addr does not change while mem_e_n is 0.
- R3: A read (req_write = 0) holds mem_e_n low for max(T_ELOW, T_SAMPLE, T_AHOLD) cycles (9 by default), and mem_w_n stays 1 throughout.
- R4: On the edge where a read raises mem_e_n, mem_q is sampled. rsp_valid is 1 for exactly that following clock cycle, and rsp_rdata carries the sampled bit. A write produces no rsp_valid.
- R5: A write (req_write = 1) lowers mem_w_n on the accept edge and holds it low for W = max(T_WPULSE, T_TURN + T_DSETUP) cycles (10). mem_e_n stays low for max(T_ELOW, T_AHOLD, W + 1) cycles (11), so mem_w_n rises at least one cycle before mem_e_n.
- R6: During a write, mem_d_oe is 1 from T_TURN cycles (6) after mem_w_n falls until the edge that raises mem_w_n. That gives at least T_DSETUP cycles of driven data before the terminating edge, and mem_d is stable and equal to the accepted write bit while driven.
- R7: After each cycle mem_e_n stays high for max(T_EHIGH, T_CYCLE minus the low time, 2) cycles (5 for both kinds by default) before the next fall.
- R8: A request held valid while a cycle or recovery is in progress is not taken: req_ready stays 0, and the request starts only after recovery expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 1 | Read data bit |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_e_n | output | 1 | Active-low chip enable |
| mem_w_n | output | 1 | Active-low write strobe |
| mem_d | output | 1 | Data bit toward the memory |
| mem_d_oe | output | 1 | Driver enable for a shared data line |
| mem_q | input | 1 | Data bit from the memory |

## Verification
A wrong phase or counter value inside the sequencer shows at the ports within one clock. It appears as an enable or write-strobe edge one cycle early or late, a driver enable that overlaps the memory's output turn-off, or a ready that rises before recovery ends. The reference model compares every output on every cycle, so any such shift is caught on the cycle it happens. Read data is served by a bench memory that returns the inverse of the stored bit until the sample interval has elapsed, so sampling too early returns a wrong bit. Data written through the write strobe is read back later, so a lost or misplaced write appears as a wrong rsp_rdata.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STROBE  = 2'd1,
    PH_RECOVER = 2'd2
  } smseq_phase_e;

  function automatic int unsigned smax2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/smseq_ticker.sv
module smseq_ticker #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/smseq_ctrl.sv
module smseq_ctrl
  import smseq_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned E_LOW_RD = 9,
  parameter int unsigned E_LOW_WR = 11,
  parameter int unsigned W_LOW    = 10,
  parameter int unsigned TURN     = 6,
  parameter int unsigned REC_RD   = 5,
  parameter int unsigned REC_WR   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic ev_accept,
  output logic ev_end,
  output logic ev_wrise,
  output logic ev_oe_on,
  output logic is_wr
);

  localparam logic [CW-1:0] RD_LAST  = CW'(E_LOW_RD - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(E_LOW_WR - 1);
  localparam logic [CW-1:0] WR_RISE  = CW'(W_LOW - 1);
  localparam logic [CW-1:0] OE_AT    = CW'(TURN - 1);
  localparam logic [CW-1:0] RRD_LAST = CW'(REC_RD - 2);
  localparam logic [CW-1:0] RWR_LAST = CW'(REC_WR - 2);

  smseq_phase_e state_q, state_d;
  logic         is_wr_q, is_wr_d;
  logic         armed_q;
  logic         rec_done;
  logic [CW-1:0] cnt;

  smseq_ticker #(.W(CW)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ev_accept | ev_end | rec_done),
    .en   (state_q != PH_IDLE),
    .cnt  (cnt)
  );

  assign req_ready = (state_q == PH_IDLE) && armed_q;
  assign ev_accept = req_ready && req_valid;
  assign ev_end    = (state_q == PH_STROBE) && (cnt == (is_wr_q ? WR_LAST : RD_LAST));
  assign ev_wrise  = (state_q == PH_STROBE) && is_wr_q && (cnt == WR_RISE);
  assign ev_oe_on  = (state_q == PH_STROBE) && is_wr_q && (cnt == OE_AT);
  assign rec_done  = (state_q == PH_RECOVER) && (cnt == (is_wr_q ? RWR_LAST : RRD_LAST));
  assign is_wr     = is_wr_q;

  always_comb begin
    state_d = state_q;
    is_wr_d = is_wr_q;
    case (state_q)
      PH_IDLE: if (ev_accept) begin
        state_d = PH_STROBE;
        is_wr_d = req_write;
      end
      PH_STROBE:  if (ev_end)   state_d = PH_RECOVER;
      PH_RECOVER: if (rec_done) state_d = PH_IDLE;
      default:                  state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      is_wr_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      is_wr_q <= is_wr_d;
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/smseq_pins.sv
module smseq_pins #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_end,
  input  logic              ev_wrise,
  input  logic              ev_oe_on,
  input  logic              is_wr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              mem_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_e_n,
  output logic              mem_w_n,
  output logic              mem_d,
  output logic              mem_d_oe,
  output logic              rsp_valid,
  output logic              rsp_rdata
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic e_q, e_d, w_q, w_d, d_q, d_d, oe_q, oe_d, rv_q, rv_d, rd_q, rd_d;

  always_comb begin
    addr_d = addr_q;
    d_d    = d_q;
    e_d    = e_q;
    w_d    = w_q;
    oe_d   = oe_q;
    if (ev_accept) begin
      addr_d = req_addr;
      d_d    = req_wdata;
      e_d    = 1'b0;
      w_d    = !req_write;
    end else begin
      if (ev_end)   e_d  = 1'b1;
      if (ev_wrise) w_d  = 1'b1;
      if (ev_oe_on) oe_d = 1'b1;
      if (ev_wrise) oe_d = 1'b0;
    end
    rv_d = ev_end && !is_wr;
    rd_d = rv_d ? mem_q : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      d_q    <= 1'b0;
      e_q    <= 1'b1;
      w_q    <= 1'b1;
      oe_q   <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      d_q    <= d_d;
      e_q    <= e_d;
      w_q    <= w_d;
      oe_q   <= oe_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_e_n   = e_q;
  assign mem_w_n   = w_q;
  assign mem_d     = d_q;
  assign mem_d_oe  = oe_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/strobe_mem_seq.sv
module strobe_mem_seq
  import smseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned T_AHOLD  = 2,
  parameter int unsigned T_ELOW   = 9,
  parameter int unsigned T_EHIGH  = 5,
  parameter int unsigned T_WPULSE = 5,
  parameter int unsigned T_DSETUP = 4,
  parameter int unsigned T_TURN   = 6,
  parameter int unsigned T_SAMPLE = 9,
  parameter int unsigned T_CYCLE  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_e_n,
  output logic              mem_w_n,
  output logic              mem_d,
  output logic              mem_d_oe,
  input  logic              mem_q
);

  localparam int unsigned TURN_EFF = smax2(T_TURN, 1);
  localparam int unsigned W_LOW    = smax2(T_WPULSE, TURN_EFF + T_DSETUP);
  localparam int unsigned E_LOW_RD = smax2(smax2(T_ELOW, T_SAMPLE), smax2(T_AHOLD, 1));
  localparam int unsigned E_LOW_WR = smax2(smax2(T_ELOW, T_AHOLD), W_LOW + 1);
  localparam int unsigned REC_RD   = smax2(smax2(T_EHIGH, 2),
                                           (T_CYCLE > E_LOW_RD) ? T_CYCLE - E_LOW_RD : 0);
  localparam int unsigned REC_WR   = smax2(smax2(T_EHIGH, 2),
                                           (T_CYCLE > E_LOW_WR) ? T_CYCLE - E_LOW_WR : 0);
  localparam int unsigned CNT_MAX  = smax2(smax2(E_LOW_RD, E_LOW_WR), smax2(REC_RD, REC_WR));
  localparam int unsigned CW       = $clog2(CNT_MAX + 1);

  logic rs1_q, rs2_q;
  logic ev_accept, ev_end, ev_wrise, ev_oe_on, is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  smseq_ctrl #(
    .CW(CW), .E_LOW_RD(E_LOW_RD), .E_LOW_WR(E_LOW_WR), .W_LOW(W_LOW),
    .TURN(TURN_EFF), .REC_RD(REC_RD), .REC_WR(REC_WR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rs2_q),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .ev_accept(ev_accept),
    .ev_end   (ev_end),
    .ev_wrise (ev_wrise),
    .ev_oe_on (ev_oe_on),
    .is_wr    (is_wr)
  );

  smseq_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk      (clk),
    .rst_n    (rs2_q),
    .ev_accept(ev_accept),
    .ev_end   (ev_end),
    .ev_wrise (ev_wrise),
    .ev_oe_on (ev_oe_on),
    .is_wr    (is_wr),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_q    (mem_q),
    .mem_addr (mem_addr),
    .mem_e_n  (mem_e_n),
    .mem_w_n  (mem_w_n),
    .mem_d    (mem_d),
    .mem_d_oe (mem_d_oe),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/smseq_chk.sv
module smseq_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned T_ELOW   = 9,
  parameter int unsigned T_EHIGH  = 5,
  parameter int unsigned T_WPULSE = 5,
  parameter int unsigned T_DSETUP = 4,
  parameter int unsigned T_TURN   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_e_n,
  input logic              mem_w_n,
  input logic              mem_d,
  input logic              mem_d_oe,
  input logic              rsp_valid
);

  logic [15:0] elo, ehi, wlo, oec;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elo  <= '0;
      ehi  <= '0;
      wlo  <= '0;
      oec  <= '0;
      seen <= 1'b0;
    end else begin
      elo  <= mem_e_n ? 16'd0 : ((elo == 16'hFFFF) ? elo : elo + 16'd1);
      ehi  <= !mem_e_n ? 16'd0 : ((ehi == 16'hFFFF) ? ehi : ehi + 16'd1);
      wlo  <= mem_w_n ? 16'd0 : ((wlo == 16'hFFFF) ? wlo : wlo + 16'd1);
      oec  <= !mem_d_oe ? 16'd0 : ((oec == 16'hFFFF) ? oec : oec + 16'd1);
      seen <= seen | (mem_e_n && (elo != 16'd0));
    end
  end

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_e_n);
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_e_n && $past(!mem_e_n)) |-> $stable(mem_addr));
  p_e_low_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_e_n) |-> (elo >= 16'(T_ELOW)));
  p_rsp_at_erise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_e_n));
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_w_inside_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n |-> !mem_e_n);
  p_w_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_w_n) |-> (wlo >= 16'(T_WPULSE)));
  p_w_before_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_e_n) |-> $past(mem_w_n));
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_d_oe) |-> (!mem_w_n && (wlo >= 16'(T_TURN))));
  p_dsetup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_w_n) && $past(mem_d_oe)) |-> (oec >= 16'(T_DSETUP)));
  p_d_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_d_oe && $past(mem_d_oe)) |-> $stable(mem_d));
  p_e_high_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(mem_e_n)) |-> (ehi >= 16'(T_EHIGH)));

endmodule

bind strobe_mem_seq smseq_chk #(
  .ADDR_W(ADDR_W), .T_ELOW(T_ELOW), .T_EHIGH(T_EHIGH),
  .T_WPULSE(T_WPULSE), .T_DSETUP(T_DSETUP), .T_TURN(T_TURN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .mem_addr (mem_addr),
  .mem_e_n  (mem_e_n),
  .mem_w_n  (mem_w_n),
  .mem_d    (mem_d),
  .mem_d_oe (mem_d_oe),
  .rsp_valid(rsp_valid)
);

// File: tb/sim_strobe_mem_seq.sv
`timescale 1ns/1ps
module sim_strobe_mem_seq;

  // Default-derived intervals, in cycles, from the requirements
  localparam int EL_R = 9;   // R3
  localparam int EL_W = 11;  // R5
  localparam int WL   = 10;  // R5
  localparam int TURN = 6;   // R6
  localparam int REC  = 5;   // R7 (both kinds)
  localparam int SAMP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [9:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata, mem_e_n, mem_w_n, mem_d, mem_d_oe, mem_q;
  logic [9:0] mem_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0, elc = 0;
  bit done = 1'b0;
  bit bmem [1024];
  bit refm [1024];

  // reference model state
  int ph = 0, mcnt = 0, rel = 0;
  bit mwr = 1'b0, md = 1'b0, erv = 1'b0, erd = 1'b0;
  logic [9:0] maddr = '0;

  always #5 clk = ~clk;

  strobe_mem_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_e_n(mem_e_n), .mem_w_n(mem_w_n), .mem_d(mem_d), .mem_d_oe(mem_d_oe),
    .mem_q(mem_q)
  );

  // bench memory: bit is wrong until the sample interval has passed
  always @(negedge clk) elc = mem_e_n ? 0 : elc + 1;
  assign mem_q = (!mem_e_n && elc >= SAMP) ? bmem[mem_addr] : ~bmem[mem_addr];
  always @(posedge mem_w_n) if (rst_n && !mem_e_n) bmem[mem_addr] = mem_d;

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mcnt = 0; rel = 0; mwr = 0; md = 0; erv = 0; erd = 0; maddr = '0;
    end else begin
      erv = 0;
      case (ph)
        0: if (rel >= 3 && req_valid) begin
             ph = 1; mcnt = 0; mwr = req_write; maddr = req_addr; md = req_wdata;
             if (req_write) refm[req_addr] = req_wdata;
           end
        1: if (mcnt == (mwr ? EL_W : EL_R) - 1) begin
             ph = 2; mcnt = 0;
             if (!mwr) begin erv = 1; erd = refm[maddr]; end
           end else mcnt++;
        default: if (mcnt == REC - 2) ph = 0; else mcnt++;
      endcase
      if (rel < 3) rel++;
    end
  end

  task automatic cmp(string tag, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      cmp((req_valid && ph != 0) ? "R8 ready" : "R2 ready", 16'(req_ready),
          16'(ph == 0 && rel >= 3));
      cmp("R2 addr", 16'(mem_addr), 16'(maddr));
      cmp(ph == 2 ? "R7 e_n" : (mwr ? "R5 e_n" : "R3 e_n"), 16'(mem_e_n), 16'(ph != 1));
      cmp("R5 w_n", 16'(mem_w_n), 16'(!(ph == 1 && mwr && mcnt < WL)));
      cmp("R6 oe", 16'(mem_d_oe), 16'(ph == 1 && mwr && mcnt >= TURN && mcnt < WL));
      if (ph == 1 && mwr && mcnt >= TURN && mcnt < WL) cmp("R6 data", 16'(mem_d), 16'(md));
      cmp("R4 rsp_valid", 16'(rsp_valid), 16'(erv));
      cmp("R4 rsp_rdata", 16'(rsp_rdata), 16'(erd));
    end
  end

  task automatic reset_checks(string tag);
    cmp({tag, " e_n"}, 16'(mem_e_n), 16'd1);
    cmp({tag, " w_n"}, 16'(mem_w_n), 16'd1);
    cmp({tag, " oe"}, 16'(mem_d_oe), 16'd0);
    cmp({tag, " rsp_valid"}, 16'(rsp_valid), 16'd0);
  endtask

  task automatic issue(bit wr, logic [9:0] a, bit d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #1; reset_checks("R1 in-reset");
    @(negedge clk); rst_n = 1;
    #2; reset_checks("R1 released");
    cmp("R1 ready-low", 16'(req_ready), 16'd0);
    idle(4);
    issue(0, 10'd3, 0);                       // read of unwritten cell
    issue(1, 10'd0, 1);
    issue(1, 10'd1023, 1);
    issue(1, 10'd5, 1);
    issue(1, 10'd6, 0);
    issue(0, 10'd0, 0);
    issue(0, 10'd1023, 0);
    issue(0, 10'd5, 0);
    issue(0, 10'd6, 0);
    idle(20);
    // R8: hold a read request valid through several busy periods
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 10'd1023;
    idle(60);
    req_valid = 0;
    idle(20);
    issue(1, 10'd1023, 0);
    issue(0, 10'd1023, 0);
    issue(1, 10'd512, 1);
    issue(0, 10'd512, 0);
    issue(1, 10'd512, 0);
    issue(0, 10'd512, 0);
    idle(20);
    // reset in the middle of a write
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'd7; req_wdata = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    idle(7);
    rst_n = 0;
    #2; reset_checks("R1 mid-write");
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule